// File: doc/BRIEF.md
# Data Memory Protection Checker

This block sits beside the data memory port and judges every load and store before it reaches memory. It holds a small table of protection entries. Each entry pairs a page base address with a descriptor that sets the page size, the validity, the dirty state, the access rights for each privilege mode, and an optional restriction to the first of the two address generators. An access that hits exactly one valid entry and satisfies that entry's rules is granted, and a granted write drives the memory write strobe. An access that breaks a rule is refused. On the next clock edge the checker latches the faulting address and a status word, and pulses an exception with cause code 0x23.

An access that matches no valid entry is refused and reported on a separate miss pulse. An access that matches more than one entry is refused and reported on a multiple-hit pulse. Neither of these raises the protection exception. Software programs the table, the enable bit and the fault registers through a write-only register port. Values take effect on the clock edge after the write. The fault registers are visible on output pins.

The access channel is a valid/ready stream in which ready is always high. The checker never applies back-pressure: it judges each valid beat in the same cycle, and an upstream stage never waits on it. Control, exception and status pins are plain levels or one-cycle pulses.

Top module: `dprot_checker`

## Requirements
- R1: After a synchronous active-high reset, all entries are invalid, checking is disabled, both fault registers read zero, and exc_valid, miss_pulse and multi_pulse are low.
- R2: While the enable bit is clear, every valid access is granted, mem_wr_en follows acc_write, and no fault, miss or multiple-hit is reported.
- R3: An entry is hit when its descriptor valid bit (bit 0) is set and the access address equals its base above the page offset. The page size is set by descriptor bits [7:6]: 0 gives 1 KB, 1 gives 4 KB, 2 gives 1 MB and 3 gives 4 MB.
- R4: A supervisor write (acc_user=0) to the hit entry faults unless supervisor-write (bit 4) is set. A supervisor read is never refused on rights.
- R5: A user write faults unless user-write (bit 3) is set. A user read faults unless user-read (bit 2) or user-write (bit 3) is set.
- R6: Any write to a hit entry whose dirty bit (bit 1) is clear faults.
- R7: An access issued by the second generator (acc_gen1=1) to an entry whose first-generator-only bit (bit 5) is set faults.
- R8: A fault is combinational: acc_fault is high and neither acc_grant nor mem_wr_en is high. On the next edge, exc_valid pulses for one cycle with exc_cause 0x23, fault_addr takes the full access address, and fault_status takes bit 0 = user, bit 1 = write, bit 2 = second generator, and bits from 3 upward = one-hot index of the hit entry.
- R9: The fault registers hold their value until a new fault or a software write. Writing zero clears them, and a capture wins over a same-cycle software write.
- R10: With checking enabled and no entry hit, the access is refused, miss_pulse rises on the next edge, and no exception or fault capture occurs.
- R11: With checking enabled and two or more entries hit, the access is refused, multi_pulse rises on the next edge, and no exception or fault capture occurs.
- R12: The register selector maps 0..N-1 to entry bases, N..2N-1 to descriptors (low 8 bits), 2N to control (bit 0 = enable), 2N+1 to fault address and 2N+2 to fault status. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access beat present |
| acc_ready | output | 1 | Always high, no back-pressure |
| acc_addr | input | ADDR_W | Data address of the access |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_user | input | 1 | 1 = user mode, 0 = supervisor |
| acc_gen1 | input | 1 | 1 = issued by second address generator |
| acc_grant | output | 1 | Access allowed (combinational) |
| acc_fault | output | 1 | Protection fault (combinational) |
| mem_wr_en | output | 1 | Write strobe passed to memory |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | SEL_W | Register selector |
| reg_wdata | input | ADDR_W | Register write data |
| exc_valid | output | 1 | One-cycle protection exception |
| exc_cause | output | 8 | Cause code, 0x23 during exc_valid |
| miss_pulse | output | 1 | No entry matched |
| multi_pulse | output | 1 | Several entries matched |
| fault_addr | output | ADDR_W | Latched faulting address |
| fault_status | output | N_ENTRIES+3 | Latched fault status word |

## Verification
The bench builds the checker with N_ENTRIES=8 and ADDR_W=32. This gives a 5-bit selector and an 11-bit status word, so every one-hot entry position in the status word and the last control and fault selectors are all exercised. Eight entries spaced 64 KB apart, with sizes drawn from all four codes, cause 1 MB and 4 MB pages to overlap their neighbours. This produces many multiple-hit accesses alongside single hits, misses just past a page edge, and every rights combination from random descriptors.

// File: rtl/dprot_pkg.sv
package dprot_pkg;

  localparam int DESC_W = 8;
  localparam logic [7:0] PROT_CAUSE = 8'h23;

  typedef struct packed {
    logic [1:0] pg_size;
    logic       gen0_only;
    logic       sup_wr;
    logic       usr_wr;
    logic       usr_rd;
    logic       dirty;
    logic       valid;
  } desc_t;

  function automatic int unsigned page_shift(input logic [1:0] code);
    case (code)
      2'd0:    page_shift = 10;
      2'd1:    page_shift = 12;
      2'd2:    page_shift = 20;
      default: page_shift = 22;
    endcase
  endfunction

endpackage

// File: rtl/dprot_entry_table.sv
module dprot_entry_table
  import dprot_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_base_en,
  input  logic              wr_desc_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [N_ENTRIES-1:0] hit_vec,
  output desc_t             hit_desc,
  output logic              any_hit,
  output logic              multi_hit
);

  desc_t desc_arr [N_ENTRIES];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic [ADDR_W-1:0] base_q;
    desc_t             desc_q;
    logic [ADDR_W-1:0] page_mask;

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
        desc_q <= '0;
      end else begin
        if (wr_base_en && wr_idx == IDX_W'(i)) base_q <= wr_data;
        if (wr_desc_en && wr_idx == IDX_W'(i)) desc_q <= desc_t'(wr_data[DESC_W-1:0]);
      end
    end

    assign page_mask   = {ADDR_W{1'b1}} << page_shift(desc_q.pg_size);
    assign hit_vec[i]  = desc_q.valid && (((acc_addr ^ base_q) & page_mask) == '0);
    assign desc_arr[i] = desc_q;
  end

  logic [IDX_W:0] hit_cnt;

  always_comb begin
    hit_desc = '0;
    hit_cnt  = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_desc = hit_desc | desc_arr[i];
        hit_cnt  = hit_cnt + 1'b1;
      end
    end
    any_hit   = (hit_cnt != '0);
    multi_hit = (hit_cnt > 1);
  end

  // A descriptor written with its valid bit clear can never produce a hit.
  assert_cleared_entry_misses_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_desc_en && !wr_data[0]) |=> !hit_vec[$past(wr_idx)]);

endmodule

// File: rtl/dprot_rights.sv
module dprot_rights
  import dprot_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  desc_t desc,
  input  logic  is_write,
  input  logic  is_user,
  input  logic  is_gen1,
  output logic  violate
);

  logic dirty_bad;
  logic gen_bad;
  logic user_bad;
  logic supv_bad;

  always_comb begin
    dirty_bad = is_write && !desc.dirty;
    gen_bad   = is_gen1 && desc.gen0_only;
    if (is_write) user_bad = is_user && !desc.usr_wr;
    else          user_bad = is_user && !(desc.usr_rd || desc.usr_wr);
    supv_bad  = !is_user && is_write && !desc.sup_wr;
    violate   = dirty_bad || gen_bad || user_bad || supv_bad;
  end

  assert_supv_read_ok_R4: assert property (@(posedge clk) disable iff (rst)
    (!is_write && !is_user && !(is_gen1 && desc.gen0_only)) |-> !violate);

  assert_clean_write_faults_R6: assert property (@(posedge clk) disable iff (rst)
    (is_write && !desc.dirty) |-> violate);

endmodule

// File: rtl/dprot_fault_regs.sv
module dprot_fault_regs #(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [STAT_W-1:0] cap_stat,
  input  logic              sw_addr_we,
  input  logic              sw_stat_we,
  input  logic [ADDR_W-1:0] sw_data,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [STAT_W-1:0] fault_status
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_addr   <= '0;
      fault_status <= '0;
    end else if (capture) begin
      fault_addr   <= cap_addr;
      fault_status <= cap_stat;
    end else begin
      if (sw_addr_we) fault_addr   <= sw_data;
      if (sw_stat_we) fault_status <= sw_data[STAT_W-1:0];
    end
  end

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!capture && !sw_addr_we && !sw_stat_we) |=> ($stable(fault_addr) && $stable(fault_status)));

endmodule

// File: rtl/dprot_checker.sv
module dprot_checker
  import dprot_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 32,
  localparam int SEL_W    = $clog2(2 * N_ENTRIES + 3),
  localparam int STAT_W   = N_ENTRIES + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_user,
  input  logic              acc_gen1,
  output logic              acc_grant,
  output logic              acc_fault,
  output logic              mem_wr_en,
  input  logic              reg_wr_en,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              exc_valid,
  output logic [7:0]        exc_cause,
  output logic              miss_pulse,
  output logic              multi_pulse,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [STAT_W-1:0] fault_status
);

  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam logic [SEL_W-1:0] SEL_DESC = SEL_W'(N_ENTRIES);
  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(2 * N_ENTRIES);
  localparam logic [SEL_W-1:0] SEL_FADR = SEL_W'(2 * N_ENTRIES + 1);
  localparam logic [SEL_W-1:0] SEL_FSTA = SEL_W'(2 * N_ENTRIES + 2);

  // register port decode
  logic             we_base, we_desc, we_ctrl, we_fadr, we_fsta;
  logic [SEL_W-1:0] desc_off;
  logic [IDX_W-1:0] tbl_idx;

  always_comb begin
    we_base  = reg_wr_en && (reg_sel < SEL_DESC);
    we_desc  = reg_wr_en && (reg_sel >= SEL_DESC) && (reg_sel < SEL_CTRL);
    we_ctrl  = reg_wr_en && (reg_sel == SEL_CTRL);
    we_fadr  = reg_wr_en && (reg_sel == SEL_FADR);
    we_fsta  = reg_wr_en && (reg_sel == SEL_FSTA);
    desc_off = reg_sel - SEL_DESC;
    tbl_idx  = we_desc ? desc_off[IDX_W-1:0] : reg_sel[IDX_W-1:0];
  end

  logic en_q;
  always_ff @(posedge clk) begin
    if (rst)          en_q <= 1'b0;
    else if (we_ctrl) en_q <= reg_wdata[0];
  end

  // lookup
  logic [N_ENTRIES-1:0] hit_vec;
  desc_t                hit_desc;
  logic                 any_hit, multi_hit;

  dprot_entry_table #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .wr_base_en(we_base),
    .wr_desc_en(we_desc),
    .wr_idx    (tbl_idx),
    .wr_data   (reg_wdata),
    .acc_addr  (acc_addr),
    .hit_vec   (hit_vec),
    .hit_desc  (hit_desc),
    .any_hit   (any_hit),
    .multi_hit (multi_hit)
  );

  logic violate;

  dprot_rights u_rights (
    .clk     (clk),
    .rst     (rst),
    .desc    (hit_desc),
    .is_write(acc_write),
    .is_user (acc_user),
    .is_gen1 (acc_gen1),
    .violate (violate)
  );

  // decision
  logic checking, single_hit;

  always_comb begin
    checking   = en_q && acc_valid;
    single_hit = any_hit && !multi_hit;
    acc_ready  = 1'b1;
    acc_fault  = checking && single_hit && violate;
    acc_grant  = acc_valid && (!en_q || (single_hit && !violate));
    mem_wr_en  = acc_grant && acc_write;
  end

  // registered reporting
  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid   <= 1'b0;
      exc_cause   <= '0;
      miss_pulse  <= 1'b0;
      multi_pulse <= 1'b0;
    end else begin
      exc_valid   <= acc_fault;
      exc_cause   <= acc_fault ? PROT_CAUSE : 8'h00;
      miss_pulse  <= checking && !any_hit;
      multi_pulse <= checking && multi_hit;
    end
  end

  dprot_fault_regs #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_fault (
    .clk         (clk),
    .rst         (rst),
    .capture     (acc_fault),
    .cap_addr    (acc_addr),
    .cap_stat    ({hit_vec, acc_gen1, acc_write, acc_user}),
    .sw_addr_we  (we_fadr),
    .sw_stat_we  (we_fsta),
    .sw_data     (reg_wdata),
    .fault_addr  (fault_addr),
    .fault_status(fault_status)
  );

  assert_disabled_grants_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !en_q) |-> (acc_grant && !acc_fault));

  assert_fault_blocks_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    acc_fault |-> (!mem_wr_en && !acc_grant));

  assert_exc_captures_addr_R8: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (fault_addr == $past(acc_addr) && exc_cause == PROT_CAUSE));

  assert_miss_no_exc_R10: assert property (@(posedge clk) disable iff (rst)
    miss_pulse |-> (!exc_valid && !multi_pulse));

  assert_multi_no_exc_R11: assert property (@(posedge clk) disable iff (rst)
    multi_pulse |-> !exc_valid);

endmodule

// File: tb/dprot_checker_tb_top.sv
`timescale 1ns/1ps
module dprot_checker_tb_top;

  localparam int N  = 8;
  localparam int AW = 32;
  localparam int SW = $clog2(2 * N + 3);
  localparam int TW = N + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          acc_valid = 0, acc_write = 0, acc_user = 0, acc_gen1 = 0;
  logic [AW-1:0] acc_addr = '0;
  logic          reg_wr_en = 0;
  logic [SW-1:0] reg_sel = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic          acc_ready, acc_grant, acc_fault, mem_wr_en;
  logic          exc_valid, miss_pulse, multi_pulse;
  logic [7:0]    exc_cause;
  logic [AW-1:0] fault_addr;
  logic [TW-1:0] fault_status;

  dprot_checker #(.N_ENTRIES(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_user(acc_user),
    .acc_gen1(acc_gen1), .acc_grant(acc_grant), .acc_fault(acc_fault),
    .mem_wr_en(mem_wr_en), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .miss_pulse(miss_pulse), .multi_pulse(multi_pulse),
    .fault_addr(fault_addr), .fault_status(fault_status)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  logic [AW-1:0] m_base [N];
  logic [7:0]    m_desc [N];
  logic          m_en;
  logic [AW-1:0] m_faddr;
  logic [TW-1:0] m_fstat;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int shift_of(input logic [1:0] c);
    case (c)
      2'd0: return 10;
      2'd1: return 12;
      2'd2: return 20;
      default: return 22;
    endcase
  endfunction

  task automatic predict(input logic [AW-1:0] a, input logic w, u, g,
                         output logic grant, fault, miss, multi,
                         output logic [TW-1:0] stat);
    int cnt = 0;
    logic [N-1:0] hv = '0;
    logic [7:0] d = '0;
    logic bad;
    for (int i = 0; i < N; i++) begin
      if (m_desc[i][0] && (((a ^ m_base[i]) >> shift_of(m_desc[i][7:6])) == 0)) begin
        cnt++;
        hv[i] = 1'b1;
        d = m_desc[i];
      end
    end
    bad = (w && !d[1]) || (g && d[5]) ||
          (u && w && !d[3]) || (u && !w && !(d[2] || d[3])) ||
          (!u && w && !d[4]);
    stat  = {hv, g, w, u};
    grant = !m_en || (cnt == 1 && !bad);
    fault = m_en && cnt == 1 && bad;
    miss  = m_en && cnt == 0;
    multi = m_en && cnt > 1;
  endtask

  task automatic regwr(input int sel, input logic [AW-1:0] data);
    @(negedge clk);
    reg_wr_en = 1; reg_sel = SW'(sel); reg_wdata = data;
    @(posedge clk); #1;
    reg_wr_en = 0;
    if (sel < N) m_base[sel] = data;
    else if (sel < 2 * N) m_desc[sel - N] = data[7:0];
    else if (sel == 2 * N) m_en = data[0];
    else if (sel == 2 * N + 1) m_faddr = data;
    else if (sel == 2 * N + 2) m_fstat = data[TW-1:0];
  endtask

  task automatic do_access(input logic [AW-1:0] a, input logic w, u, g, input string tag);
    logic eg, ef, em, emu;
    logic [TW-1:0] es;
    predict(a, w, u, g, eg, ef, em, emu, es);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_write = w; acc_user = u; acc_gen1 = g;
    #2;
    check({tag, " grant/fault/strobe/ready"}, {acc_grant, acc_fault, mem_wr_en, acc_ready},
          {eg, ef, eg & w, 1'b1});
    @(posedge clk); #1;
    acc_valid = 0;
    if (ef) begin m_faddr = a; m_fstat = es; end
    check({tag, " exc/miss/multi"}, {exc_valid, miss_pulse, multi_pulse}, {ef, em, emu});
    check({tag, " cause"}, exc_cause, ef ? 8'h23 : 8'h00);
    check({tag, " fault_addr"}, fault_addr, m_faddr);
    check({tag, " fault_status"}, fault_status, m_fstat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin m_base[i] = '0; m_desc[i] = '0; end
    m_en = 0; m_faddr = '0; m_fstat = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    check("R1 reset outputs", {exc_valid, miss_pulse, multi_pulse, exc_cause}, 11'h0);
    check("R1 reset fault_addr", fault_addr, 0);
    check("R1 reset fault_status", fault_status, 0);
    // R2 disabled: everything granted
    do_access(32'h0000_0800, 1, 1, 1, "R2");
    do_access(32'h1234_5678, 0, 0, 0, "R2");
    // R12 enable; R1 entries invalid -> R10 miss
    regwr(2 * N, 1);
    do_access(32'h0000_0800, 1, 0, 0, "R10/R1");
    // entry0: 1 KB at 0x800, valid+dirty only -> supervisor write faults (R4, R8)
    regwr(0, 32'h800);
    regwr(N + 0, 32'h03);
    do_access(32'h0000_0800, 1, 0, 0, "R4/R8");
    check("R8 status literal", fault_status, 11'h00A);
    // R9 hold over a miss, then clear by writing zero
    do_access(32'h0000_0C00, 0, 0, 0, "R9/R3 edge miss");
    regwr(2 * N + 1, 0);
    regwr(2 * N + 2, 0);
    check("R9 cleared addr", fault_addr, 0);
    check("R9 cleared status", fault_status, 0);
    // supervisor read allowed (R4), last word of 1 KB page hits (R3)
    do_access(32'h0000_0BFC, 0, 0, 0, "R4/R3");
    // add supervisor write -> granted write
    regwr(N + 0, 32'h13);
    do_access(32'h0000_0800, 1, 0, 0, "R4 grant");
    // R5 user rights
    do_access(32'h0000_0800, 0, 1, 0, "R5 user read none");
    regwr(N + 0, 32'h17);
    do_access(32'h0000_0804, 0, 1, 0, "R5 user read ok");
    do_access(32'h0000_0804, 1, 1, 0, "R5 user write ro");
    regwr(N + 0, 32'h1F);
    do_access(32'h0000_0808, 1, 1, 0, "R5 user write ok");
    // R6 clean page
    regwr(N + 0, 32'h1D);
    do_access(32'h0000_0808, 1, 1, 0, "R6");
    do_access(32'h0000_0808, 0, 1, 0, "R6 read ok");
    // R7 first generator only
    regwr(N + 0, 32'h3F);
    do_access(32'h0000_0810, 0, 1, 1, "R7");
    do_access(32'h0000_0810, 0, 1, 0, "R7 gen0 ok");
    // R3 4 MB page at entry 7 -> status one-hot at top bit
    regwr(7, 32'h0040_0000);
    regwr(N + 7, 32'hDF);
    do_access(32'h007F_FFFC, 1, 0, 0, "R3 4MB hit");
    do_access(32'h0080_0000, 1, 0, 0, "R3 4MB edge");
    regwr(N + 7, 32'hCB);
    do_access(32'h0050_0000, 1, 0, 0, "R8 entry7");
    // R11 overlapping entry
    regwr(3, 32'h0040_0000);
    regwr(N + 3, 32'h1F);
    do_access(32'h0040_0100, 0, 1, 0, "R11");
    // R2 disable again
    regwr(2 * N, 0);
    do_access(32'h0040_0100, 1, 1, 1, "R2 off");
    regwr(2 * N, 1);
    // random rounds
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < N; i++) begin
        logic [7:0] d;
        d = 8'($urandom);
        if ($urandom % 4 != 0) d[0] = 1'b1;
        regwr(i, AW'(i) << 16);
        regwr(N + i, {24'h0, d});
      end
      if ($urandom % 8 == 0) regwr(2 * N, 0);
      else regwr(2 * N, 1);
      for (int k = 0; k < 40; k++) begin
        logic [AW-1:0] a;
        if ($urandom % 10 == 0) a = $urandom;
        else a = (AW'($urandom % N) << 16) + AW'($urandom % 8192);
        a[1:0] = 2'b00;
        do_access(a, 1'($urandom), 1'($urandom), 1'($urandom), "R3-random R12");
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule